// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host register bus a window onto the registers of a slower peripheral core. The host never addresses the core directly. It programs an 8-bit core register address into a control word and sets a request bit there. The bridge then runs a strobe-and-acknowledge handshake with the core and places the returned word in a read-value register. When the read finishes, the bridge raises a completion status bit, which drives an interrupt line.

Host writes aimed at the core go through the same path. The host writes a data word into a forwarding slot. The bridge holds a write strobe toward the core until the core acknowledges it. While a read or a forwarded write is outstanding, the request bit reads back as a busy flag. A separate abort bit lets software cancel the outstanding access without waiting for the core.

Top module: `regBridge`

## Requirements
- R1: After reset the control word, read-value register, completion status, interrupt output and both core strobes are all 0.
- R2: The host address selects a register. Address 0 is the control word, address 1 is the read-only read value, address 2 is the completion status in bit 0, and address 3 is the forwarded-write data. In the control word, bit 31 is request/busy, bit 30 is abort and bits 9:2 hold the core address. All other control bits read as 0.
- R3: Writing a control word with bit 31 set while idle starts a core read. The read strobe is high from the next cycle and the core address equals the written bits 9:2. A control write with bits 31 and 30 both 0 starts nothing.
- R4: The strobe, core address and core write data stay unchanged until the core acknowledges or an abort arrives.
- R5: When the core acknowledges a read, its data is stored in the read-value register. In the next cycle the read strobe and busy bit are 0, and the completion status and interrupt are 1.
- R6: A host write to address 3 while idle forwards that data to the core with the write strobe at the programmed address. Busy reads 1 until the acknowledge, and the completion status is not set. The read and write strobes are never high together.
- R7: While busy, a control write with the request bit set, a write to address 3 and a change of the address field are all ignored.
- R8: A control write with bit 30 set drops any core strobe in the next cycle and clears busy. The abort bit reads 1 for exactly that one cycle and then returns to 0. An aborted access sets no status.
- R9: If bits 31 and 30 are written as 1 together, the abort wins and no core access starts.
- R10: If an abort is written in the same cycle the core acknowledges a read, the abort wins. The read-value register keeps its old content and no status is set.
- R11: Writing 1 to status bit 0 clears it and writing 0 leaves it unchanged. If a read completes in the same cycle as the clear, the status stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostSel | input | 1 | Host register access strobe |
| hostWrite | input | 1 | Host access is a write when 1 |
| hostAddr | input | 2 | Host register select |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data for the selected register |
| coreAddr | output | 8 | Core register address |
| coreRd | output | 1 | Core read strobe |
| coreWr | output | 1 | Core write strobe |
| coreWdata | output | 32 | Core write data |
| coreRdata | input | 32 | Core read data, valid with the acknowledge |
| coreAck | input | 1 | One-cycle core acknowledge |
| irq | output | 1 | Read-completion interrupt, equal to the status bit |

## Verification
Two pairs of events can land in the same clock cycle. In the first, an abort write meets the core's acknowledge of a read. In the second, a read completion meets a host write-1-to-clear of the status bit. The bench provokes each pair on purpose by holding the core acknowledge under manual control and driving the host write in that same cycle. In the first case it checks that the read value is unchanged and the interrupt stays low. In the second case it checks that the interrupt stays high.

// File: rtl/regBridgePkg.sv
package regBridgePkg;

  localparam int HOST_AW = 2;

  localparam logic [HOST_AW-1:0] HA_CTRL = 2'd0;
  localparam logic [HOST_AW-1:0] HA_RVAL = 2'd1;
  localparam logic [HOST_AW-1:0] HA_STS  = 2'd2;
  localparam logic [HOST_AW-1:0] HA_WDAT = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_ABORT
  } bridgeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic loadWdata;
    logic captureRd;
    logic setInt;
    logic clrInt;
    logic busy;
    logic aborting;
  } bridgeCtl_t;

endpackage

// File: rtl/regBridgeCtrl.sv
module regBridgeCtrl
  import regBridgePkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostSel,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               reqBit,
  input  logic               abtBit,
  input  logic               clrBit,
  input  logic               coreAck,
  output bridgeCtl_t         ctl,
  output logic               coreRd,
  output logic               coreWr
);

  bridgeState_t state, stateNext;
  logic ctrlWr, fwdWr, stsWr, abortReq, isIdle, startRd;

  always_comb begin
    ctrlWr   = hostSel && hostWrite && (hostAddr == HA_CTRL);
    fwdWr    = hostSel && hostWrite && (hostAddr == HA_WDAT);
    stsWr    = hostSel && hostWrite && (hostAddr == HA_STS);
    abortReq = ctrlWr && abtBit;
    isIdle   = (state == ST_IDLE);
    startRd  = ctrlWr && reqBit && !abortReq && isIdle;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (abortReq)     stateNext = ST_ABORT;
        else if (startRd) stateNext = ST_READ;
        else if (fwdWr)   stateNext = ST_WRITE;
      end
      ST_READ, ST_WRITE: begin
        if (abortReq)     stateNext = ST_ABORT;
        else if (coreAck) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl.loadAddr  = ctrlWr && isIdle;
    ctl.loadWdata = fwdWr && isIdle;
    ctl.captureRd = (state == ST_READ) && coreAck && !abortReq;
    ctl.setInt    = (state == ST_READ) && coreAck && !abortReq;
    ctl.clrInt    = stsWr && clrBit;
    ctl.busy      = (state == ST_READ) || (state == ST_WRITE);
    ctl.aborting  = (state == ST_ABORT);
    coreRd        = (state == ST_READ);
    coreWr        = (state == ST_WRITE);
  end

endmodule

// File: rtl/regBridgeData.sv
module regBridgeData
  import regBridgePkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CADDR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  bridgeCtl_t         ctl,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0]  hostWdata,
  input  logic [DATA_W-1:0]  coreRdata,
  output logic [CADDR_W-1:0] coreAddr,
  output logic [DATA_W-1:0]  coreWdata,
  output logic [DATA_W-1:0]  hostRdata,
  output logic               irq
);

  localparam int ADDR_LSB = 2;
  localparam int ADDR_MSB = ADDR_LSB + CADDR_W - 1;
  localparam int BUSY_POS = DATA_W - 1;
  localparam int ABT_POS  = DATA_W - 2;

  logic [CADDR_W-1:0] addrReg;
  logic [DATA_W-1:0]  wdataReg, rvalReg;
  logic               intSts;
  logic [DATA_W-1:0]  ctrlWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rvalReg  <= '0;
      intSts   <= 1'b0;
    end else begin
      if (ctl.loadAddr)  addrReg  <= hostWdata[ADDR_MSB:ADDR_LSB];
      if (ctl.loadWdata) wdataReg <= hostWdata;
      if (ctl.captureRd) rvalReg  <= coreRdata;
      if (ctl.setInt)      intSts <= 1'b1;
      else if (ctl.clrInt) intSts <= 1'b0;
    end
  end

  always_comb begin
    ctrlWord                    = '0;
    ctrlWord[BUSY_POS]          = ctl.busy;
    ctrlWord[ABT_POS]           = ctl.aborting;
    ctrlWord[ADDR_MSB:ADDR_LSB] = addrReg;
  end

  always_comb begin
    unique case (hostAddr)
      HA_CTRL: hostRdata = ctrlWord;
      HA_RVAL: hostRdata = rvalReg;
      HA_STS:  hostRdata = {{(DATA_W-1){1'b0}}, intSts};
      default: hostRdata = wdataReg;
    endcase
  end

  assign coreAddr  = addrReg;
  assign coreWdata = wdataReg;
  assign irq       = intSts;

endmodule

// File: rtl/regBridge.sv
module regBridge
  import regBridgePkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CADDR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostSel,
  input  logic               hostWrite,
  input  logic [1:0]         hostAddr,
  input  logic [DATA_W-1:0]  hostWdata,
  output logic [DATA_W-1:0]  hostRdata,
  output logic [CADDR_W-1:0] coreAddr,
  output logic               coreRd,
  output logic               coreWr,
  output logic [DATA_W-1:0]  coreWdata,
  input  logic [DATA_W-1:0]  coreRdata,
  input  logic               coreAck,
  output logic               irq
);

  bridgeCtl_t ctl;

  regBridgeCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostSel   (hostSel),
    .hostWrite (hostWrite),
    .hostAddr  (hostAddr),
    .reqBit    (hostWdata[DATA_W-1]),
    .abtBit    (hostWdata[DATA_W-2]),
    .clrBit    (hostWdata[0]),
    .coreAck   (coreAck),
    .ctl       (ctl),
    .coreRd    (coreRd),
    .coreWr    (coreWr)
  );

  regBridgeData #(
    .DATA_W  (DATA_W),
    .CADDR_W (CADDR_W)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .coreRdata (coreRdata),
    .coreAddr  (coreAddr),
    .coreWdata (coreWdata),
    .hostRdata (hostRdata),
    .irq       (irq)
  );

endmodule

// File: rtl/regBridgeChk.sv
module regBridgeChk #(
  parameter int DATA_W  = 32,
  parameter int CADDR_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostSel,
  input logic               hostWrite,
  input logic [1:0]         hostAddr,
  input logic [DATA_W-1:0]  hostWdata,
  input logic [CADDR_W-1:0] coreAddr,
  input logic               coreRd,
  input logic               coreWr,
  input logic [DATA_W-1:0]  coreWdata,
  input logic               coreAck,
  input logic               irq
);

  logic abtWr;
  assign abtWr = hostSel && hostWrite && (hostAddr == 2'd0) && hostWdata[DATA_W-2];

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((coreRd || coreWr) && !coreAck && !abtWr)
      |=> ($stable(coreRd) && $stable(coreWr) && $stable(coreAddr) && $stable(coreWdata)));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rstN)
    (abtWr && (coreRd || coreWr)) |=> (!coreRd && !coreWr));

  assert_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(coreRd && coreWr));

  assert_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    (coreRd && coreAck && !abtWr) |=> (!coreRd && irq));

  assert_irqsrc_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(coreRd && coreAck));

  assert_abtack_R10: assert property (@(posedge clk) disable iff (!rstN)
    (abtWr && coreRd && coreAck && !irq) |=> !irq);

endmodule

bind regBridge regBridgeChk #(
  .DATA_W  (DATA_W),
  .CADDR_W (CADDR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostSel   (hostSel),
  .hostWrite (hostWrite),
  .hostAddr  (hostAddr),
  .hostWdata (hostWdata),
  .coreAddr  (coreAddr),
  .coreRd    (coreRd),
  .coreWr    (coreWr),
  .coreWdata (coreWdata),
  .coreAck   (coreAck),
  .irq       (irq)
);

// File: tb/regBridge_tb.sv
module regBridge_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0, hostWrite = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic [7:0]  coreAddr;
  logic        coreRd, coreWr;
  logic [31:0] coreWdata, coreRdata;
  logic        coreAck;
  logic        irq;

  logic        autoCore = 1'b0;
  logic        autoAck = 1'b0, manAck = 1'b0;
  logic [31:0] autoData = '0, manData = '0;
  int          lat = 0, waitCnt = 0;
  logic [7:0]  lastWrA = '0;
  logic [31:0] lastWrD = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  assign coreAck   = autoCore ? autoAck  : manAck;
  assign coreRdata = autoCore ? autoData : manData;

  regBridge u_dut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .coreAddr(coreAddr), .coreRd(coreRd), .coreWr(coreWr),
    .coreWdata(coreWdata), .coreRdata(coreRdata), .coreAck(coreAck), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] pat(input logic [7:0] a);
    return {a, ~a, a ^ 8'hA5, 8'h3C};
  endfunction

  // behavioural core with programmable latency
  always @(negedge clk) begin
    if (autoCore) begin
      if (autoAck) begin
        autoAck = 1'b0;
        waitCnt = 0;
      end else if (coreRd || coreWr) begin
        if (waitCnt >= lat) begin
          autoAck  = 1'b1;
          autoData = pat(coreAddr);
          if (coreWr) begin
            lastWrA = coreAddr;
            lastWrD = coreWdata;
          end
          waitCnt = 0;
        end else waitCnt++;
      end else waitCnt = 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    hostSel = 1'b1; hostWrite = 1'b1; hostAddr = a; hostWdata = d;
    @(posedge clk);
    @(negedge clk);
    hostSel = 1'b0; hostWrite = 1'b0; hostWdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    hostSel = 1'b1; hostWrite = 1'b0; hostAddr = a;
    #1 d = hostRdata;
    hostSel = 1'b0;
  endtask

  task automatic manualAck(input logic [31:0] d);
    manAck = 1'b1; manData = d;
    @(posedge clk);
    @(negedge clk);
    manAck = 1'b0;
  endtask

  task automatic waitIdle(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 40; i++) begin
      rd(2'd0, v);
      if (!v[31]) return;
      @(negedge clk);
    end
    check(tag, 32'h1, 32'h0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 32'h0);
    rd(2'd1, v); check("R1 rval", v, 32'h0);
    rd(2'd2, v); check("R1 sts", v, 32'h0);
    check("R1 strobes", {irq, coreRd, coreWr}, 32'h0);

    // R2 reserved bits read zero, R3 zero bits start nothing
    wr(2'd0, 32'h3FFF_FFFF);
    rd(2'd0, v); check("R2 ctrl readback", v, 32'h0000_03FC);
    check("R3 no start", {coreRd, coreWr}, 32'h0);

    // R3 start read, R4 hold
    wr(2'd0, 32'h8000_0000 | (32'h12 << 2));
    check("R3 rd strobe", {coreRd, coreAddr}, {23'h0, 1'b1, 8'h12});
    repeat (3) @(negedge clk);
    check("R4 held", {coreRd, coreAddr}, {23'h0, 1'b1, 8'h12});

    // R7 ignored while busy
    wr(2'd0, 32'h8000_0000 | (32'h55 << 2));
    check("R7 addr kept", {24'h0, coreAddr}, 32'h12);
    wr(2'd3, 32'h0000_DEAD);
    check("R7 no fwd", {coreWr, coreRd}, 32'h1);
    rd(2'd0, v); check("R7 ctrl", v, 32'h8000_0048);

    // R5 completion
    manualAck(32'hCAFE_F00D);
    rd(2'd0, v); check("R5 busy clear", v, 32'h0000_0048);
    rd(2'd1, v); check("R5 rval", v, 32'hCAFE_F00D);
    rd(2'd2, v); check("R5 sts", v, 32'h1);
    check("R5 irq", {31'h0, irq}, 32'h1);

    // R11 W1C
    wr(2'd2, 32'h0);
    check("R11 zero keeps", {31'h0, irq}, 32'h1);
    wr(2'd2, 32'h1);
    check("R11 clear", {31'h0, irq}, 32'h0);

    // R8 abort read
    wr(2'd0, 32'h8000_0000 | (32'h20 << 2));
    check("R8 started", {31'h0, coreRd}, 32'h1);
    wr(2'd0, 32'h4000_0000 | (32'h20 << 2));
    check("R8 strobe drop", {coreRd, coreWr}, 32'h0);
    rd(2'd0, v); check("R8 abort bit", v, 32'h4000_0080);
    @(negedge clk);
    rd(2'd0, v); check("R8 abort self-clear", v, 32'h0000_0080);
    check("R8 no irq", {31'h0, irq}, 32'h0);

    // R8 abort forwarded write
    wr(2'd3, 32'h0000_1234);
    check("R6 wr strobe", {coreWr, coreWdata}, {31'h1, 1'b0} >> 1 | 32'h0 ? 33'h1_0000_1234 : 33'h1_0000_1234);
    wr(2'd0, 32'h4000_0000);
    check("R8 wr drop", {coreRd, coreWr}, 32'h0);
    @(negedge clk);

    // R9 abort beats request
    wr(2'd0, 32'hC000_0000 | (32'h30 << 2));
    rd(2'd0, v); check("R9 abort wins", v, 32'h4000_00C0);
    check("R9 no strobe", {coreRd, coreWr}, 32'h0);
    @(negedge clk);
    check("R9 still none", {coreRd, coreWr}, 32'h0);

    // R10 abort in ack cycle
    wr(2'd0, 32'h8000_0000 | (32'h31 << 2));
    manAck = 1'b1; manData = 32'h1111_1111;
    hostSel = 1'b1; hostWrite = 1'b1; hostAddr = 2'd0; hostWdata = 32'h4000_0000;
    @(posedge clk);
    @(negedge clk);
    manAck = 1'b0; hostSel = 1'b0; hostWrite = 1'b0; hostWdata = '0;
    check("R10 irq low", {31'h0, irq}, 32'h0);
    rd(2'd1, v); check("R10 rval kept", v, 32'hCAFE_F00D);
    check("R10 strobe", {31'h0, coreRd}, 32'h0);
    @(negedge clk);

    // R11 set beats clear
    wr(2'd0, 32'h8000_0000 | (32'h40 << 2));
    manAck = 1'b1; manData = 32'h0000_2222;
    hostSel = 1'b1; hostWrite = 1'b1; hostAddr = 2'd2; hostWdata = 32'h1;
    @(posedge clk);
    @(negedge clk);
    manAck = 1'b0; hostSel = 1'b0; hostWrite = 1'b0; hostWdata = '0;
    check("R11 set wins", {31'h0, irq}, 32'h1);
    rd(2'd1, v); check("R5 rval second", v, 32'h0000_2222);
    wr(2'd2, 32'h1);

    // random traffic
    autoCore = 1'b1;
    for (int n = 0; n < 150; n++) begin
      logic [7:0]  a;
      logic [31:0] dat;
      a   = 8'($urandom);
      dat = $urandom;
      lat = $urandom_range(0, 4);
      if ($urandom_range(0, 1) == 0) begin
        wr(2'd0, 32'h8000_0000 | ({24'h0, a} << 2));
        check("R3 rnd start", {coreRd, coreAddr}, {23'h0, 1'b1, a});
        waitIdle("R5 rnd timeout");
        rd(2'd1, v); check("R5 rnd rval", v, pat(a));
        check("R5 rnd irq", {31'h0, irq}, 32'h1);
        wr(2'd2, 32'h1);
        check("R11 rnd clear", {31'h0, irq}, 32'h0);
      end else begin
        wr(2'd0, {22'h0, a, 2'b00});
        wr(2'd3, dat);
        rd(2'd0, v);
        check("R6 rnd busy", {v[31], coreWr}, 32'h3);
        waitIdle("R6 rnd timeout");
        check("R6 rnd addr", {24'h0, lastWrA}, {24'h0, a});
        check("R6 rnd data", lastWrD, dat);
        check("R6 rnd no irq", {31'h0, irq}, 32'h0);
      end
      @(negedge clk);
    end

    finishRun();
  end

endmodule